// File: doc/BRIEF.md
# Multi-Port Rule Prefetcher

This block reads a ruleset out of external memory and delivers it, one rule per transfer, to a packet matching engine. The ruleset is stored as consecutive 128-byte blocks, and each block holds two 64-byte rules. Eight memory request ports each have their own prefetch unit. Unit k reads blocks k, k+8, k+16 and so on in increasing address order. It has at most one read in flight. Each read comes back as eight 16-byte segments. The unit gathers all eight segments into one buffer, and the buffer then presents two rules. A round-robin merger takes the ready rules from the eight units and forms one output stream. A downstream FIFO throttles that stream through a ready signal.

A pulse on `pass_start` begins a match pass. On that pulse the block samples `rule_count`, and that value bounds how many rules the pass fetches and emits. Once every block of the current pass has been requested, the units do not wait. Each unit whose index is below one eighth of the rule count reads its first block of the next pass, which covers at most a quarter of the rules. It holds that block and emits none of it until the next pass is accepted. It then skips that block when it fetches the next pass. If the new count is smaller than the prefetched range, the held rules that now fall outside the ruleset are discarded.

Top module: `rule_prefetcher`

## Requirements
- R1: After reset, and before any `pass_start`, no port raises `req_valid` and `rule_valid` stays low.
- R2: Port k requests only at byte addresses 128*b, where b mod 8 equals k. Within a pass each request is 8 blocks beyond the previous one, and each pass restarts at block k. While a request waits for `req_ready`, its address does not change.
- R3: A port issues no new request from the acceptance of a read until its eighth response segment has arrived, nor while its unit still holds rules that have not been emitted.
- R4: In a completed read, segment s fills bits [128*s+127 : 128*s] of the 1024-bit buffer. Rule 2b is buffer bits [511:0], which are segments 0 to 3, and rule 2b+1 is bits [1023:512], which are segments 4 to 7.
- R5: A pass accepted with count C emits exactly C rules, and each index 0 to C-1 appears once. When C is odd, the last block contributes only rule C-1. A change on `rule_count` between accepted pulses has no effect.
- R6: While `rule_valid` is high and `rule_ready` is low, `rule_valid` stays high and `rule_data` holds its value into the next cycle.
- R7: After the merger grants unit u, the next grant goes to the first unit that has a rule ready, searching cyclically from u+1. With all eight units ready, eight consecutive grants therefore visit eight consecutive unit indices modulo 8.
- R8: Once every block of a pass with count C has been requested, each unit k with k < floor(C/8) requests block k of the next pass, which is at most C/4 rules. None of those rules is emitted before the next accepted `pass_start`, and no unit requests that block a second time in the next pass.
- R9: A `pass_start` pulse that arrives while any rule of the current pass is still unrequested or unemitted is ignored. The sampled count and the set of emitted rules do not change.
- R10: When a pass is accepted, a held next-pass rule whose index is not below the new count is discarded and never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_start | input | 1 | Pulse that starts a match pass |
| rule_count | input | 21 | Number of rules in the ruleset, sampled on an accepted pass start |
| req_valid | output | 8 | Read request per port |
| req_ready | input | 8 | Memory accepts the read request per port |
| req_addr | output | 256 | Byte address per port, 32 bits each, port k in bits [32k+31:32k] |
| rsp_valid | input | 8 | One response segment is present per port |
| rsp_data | input | 1024 | Response segment per port, 128 bits each |
| rule_valid | output | 1 | A rule is on `rule_data` |
| rule_ready | input | 1 | The downstream FIFO takes the rule |
| rule_data | output | 512 | Merged rule stream |

## Verification
The hardest state to reach is a held next-pass block that is then discarded, because it needs two passes in a row. The first pass must be large enough to prefetch several blocks. The second pass must be accepted with a count smaller than the prefetched range. The stimulus runs two passes of 40 rules, which leave blocks 0 to 4 held. It then starts a pass of 6 rules and expects exactly rules 0 to 5, with no new reads. A separate pass holds `rule_ready` low until all eight units are full, so the round-robin order can be seen over eight consecutive grants. Another pass pulses `pass_start` with a larger count partway through its emission.

// File: rtl/rule_prefetcher.sv
module rule_prefetcher #(
  parameter int N      = 8,
  parameter int SEG_W  = 128,
  parameter int SEGS   = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 21,
  localparam int RULE_W = SEG_W * SEGS / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pass_start,
  input  logic [CNT_W-1:0]    rule_count,
  output logic [N-1:0]        req_valid,
  input  logic [N-1:0]        req_ready,
  output logic [N*ADDR_W-1:0] req_addr,
  input  logic [N-1:0]        rsp_valid,
  input  logic [N*SEG_W-1:0]  rsp_data,
  output logic                rule_valid,
  input  logic                rule_ready,
  output logic [RULE_W-1:0]   rule_data
);
  localparam int BLK_SH = $clog2(SEG_W * SEGS / 8);
  localparam int SEG_CW = $clog2(SEGS);
  localparam int PW     = (N > 1) ? $clog2(N) : 1;
  localparam int BW     = CNT_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_FULL} ust_t;

  ust_t                    st    [N];
  logic [BW-1:0]           ublk  [N];
  logic [BW-1:0]           cblk  [N];
  logic [SEG_CW-1:0]       seg   [N];
  logic [SEGS*SEG_W-1:0]   bufm  [N];
  logic [1:0]              rem   [N];
  logic [1:0]              newr  [N];
  logic [BW-1:0]           req_blk [N];
  logic [N-1:0]            rsel, ahd, adone, want_cur, want_ahd, elig, fire;
  logic [CNT_W-1:0]        cnt, alim, ceff;
  logic [BW-1:0]           nblk;
  logic [PW-1:0]           ptr, gnt, hgnt;
  logic                    hold_q, all_req, busy, take, acc;

  function automatic logic [1:0] vr(logic [BW-1:0] b, logic [CNT_W-1:0] c);
    logic [BW:0] lo, cc;
    lo = {b, 1'b0};
    cc = (BW+1)'(c);
    if (lo + (BW+1)'(1) < cc) return 2'd2;
    else if (lo < cc)         return 2'd1;
    else                      return 2'd0;
  endfunction

  assign nblk = ({1'b0, cnt} + BW'(1)) >> 1;
  assign alim = cnt >> 3;
  assign take = pass_start && !busy;
  assign ceff = take ? rule_count : cnt;
  assign acc  = rule_valid && rule_ready;

  always_comb begin
    all_req = 1'b1;
    busy    = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (ublk[k] < nblk) all_req = 1'b0;
      if (st[k] != S_IDLE && !ahd[k]) busy = 1'b1;
    end
    if (!all_req) busy = 1'b1;
    for (int k = 0; k < N; k++) begin
      want_cur[k] = ublk[k] < nblk;
      want_ahd[k] = all_req && !adone[k] && (CNT_W'(k) < alim);
      req_valid[k] = (st[k] == S_IDLE) && (want_cur[k] || want_ahd[k]);
      req_blk[k]  = want_cur[k] ? ublk[k] : BW'(k);
      req_addr[k*ADDR_W +: ADDR_W] = ADDR_W'(req_blk[k]) << BLK_SH;
      fire[k]     = req_valid[k] && req_ready[k];
      elig[k]     = (st[k] == S_FULL) && !ahd[k];
      newr[k]     = vr(cblk[k], ceff);
    end
  end

  always_comb begin
    rule_valid = 1'b0;
    gnt        = ptr;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (int'(ptr) + i) % N;
      if (!rule_valid && elig[idx]) begin
        rule_valid = 1'b1;
        gnt        = PW'(idx);
      end
    end
    if (hold_q) begin
      rule_valid = 1'b1;
      gnt        = hgnt;
    end
  end

  assign rule_data = rsel[gnt] ? bufm[gnt][SEGS*SEG_W-1 -: RULE_W] : bufm[gnt][RULE_W-1:0];

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++)
      if (st[k] == S_WAIT && rsp_valid[k])
        bufm[k][seg[k]*SEG_W +: SEG_W] <= rsp_data[k*SEG_W +: SEG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ptr    <= '0;
      hgnt   <= '0;
      hold_q <= 1'b0;
      rsel   <= '0;
      ahd    <= '0;
      adone  <= '0;
      for (int k = 0; k < N; k++) begin
        st[k]   <= S_IDLE;
        ublk[k] <= BW'(k);
        cblk[k] <= '0;
        seg[k]  <= '0;
        rem[k]  <= '0;
      end
    end else begin
      if (take) cnt <= rule_count;
      hold_q <= rule_valid && !rule_ready;
      hgnt   <= gnt;
      if (acc) ptr <= PW'((int'(gnt) + 1) % N);
      for (int k = 0; k < N; k++) begin
        case (st[k])
          S_IDLE: if (fire[k]) begin
            st[k]   <= S_WAIT;
            cblk[k] <= req_blk[k];
            seg[k]  <= '0;
            if (want_cur[k]) begin
              ublk[k] <= ublk[k] + BW'(N);
              ahd[k]  <= 1'b0;
            end else begin
              ahd[k]   <= 1'b1;
              adone[k] <= 1'b1;
            end
          end
          S_WAIT: if (rsp_valid[k]) begin
            seg[k] <= seg[k] + 1'b1;
            if (seg[k] == SEG_CW'(SEGS-1)) begin
              rem[k]  <= newr[k];
              rsel[k] <= 1'b0;
              st[k]   <= (newr[k] == 2'd0) ? S_IDLE : S_FULL;
            end
          end
          S_FULL: begin
            if (acc && gnt == PW'(k) && !ahd[k]) begin
              rem[k]  <= rem[k] - 2'd1;
              rsel[k] <= 1'b1;
              if (rem[k] == 2'd1) st[k] <= S_IDLE;
            end
            if (take && ahd[k]) begin
              rem[k] <= newr[k];
              if (newr[k] == 2'd0) st[k] <= S_IDLE;
            end
          end
          default: st[k] <= S_IDLE;
        endcase
        if (take) begin
          ahd[k]   <= 1'b0;
          adone[k] <= 1'b0;
          ublk[k]  <= (adone[k] || (fire[k] && !want_cur[k])) ? BW'(k + N) : BW'(k);
        end
      end
    end
  end

  logic [CNT_W:0] em;
  always_ff @(posedge clk) begin
    if (!rst_n)   em <= '0;
    else if (take) em <= '0;
    else if (acc)  em <= em + 1'b1;
  end

  p_pass_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (em < {1'b0, cnt}));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rule_valid && !rule_ready |=> rule_valid && $stable(rule_data));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start && busy |=> $stable(cnt));

  p_ahead_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($countones(adone) <= int'(alim)));

  for (genvar k = 0; k < N; k++) begin : g_chk
    logic              oc;
    logic [SEG_CW-1:0] bt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        oc <= 1'b0;
        bt <= '0;
      end else begin
        if (fire[k]) oc <= 1'b1;
        if (rsp_valid[k]) begin
          bt <= bt + 1'b1;
          if (bt == SEG_CW'(SEGS-1)) oc <= 1'b0;
        end
      end
    end

    p_one_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[k] |-> !oc);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[k] && !req_ready[k] |=> req_valid[k] && $stable(req_addr[k*ADDR_W +: ADDR_W]));

    p_addr_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[k] |-> ((int'(req_addr[k*ADDR_W +: ADDR_W] >> BLK_SH) % N) == k));
  end
endmodule

// File: tb/test_rule_prefetcher.sv
module test_rule_prefetcher;
  localparam int N = 8, SEG_W = 128, SEGS = 8, ADDR_W = 32, CNT_W = 21, RULE_W = 512;

  logic                clk, rst_n, pass_start, rule_valid, rule_ready;
  logic [CNT_W-1:0]    rule_count;
  logic [N-1:0]        req_valid, req_ready, rsp_valid;
  logic [N*ADDR_W-1:0] req_addr;
  logic [N*SEG_W-1:0]  rsp_data;
  logic [RULE_W-1:0]   rule_data;

  rule_prefetcher i_rule_prefetcher (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .rule_count(rule_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rule_valid(rule_valid), .rule_ready(rule_ready), .rule_data(rule_data));

  int checks = 0, errors = 0;
  int cyc = 0, rmode = 0, qmode = 0, gap_mode = 0;
  int total_req = 0, em_cnt = 0, dup = 0, r2_err = 0, r3_err = 0, r4_err = 0, r6_err = 0;
  int logu [8];
  logic [63:0] seen;

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] segw(logic [31:0] a);
    return {~a, a ^ 32'h1357_9BDF, a + 32'd1, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    rule_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc[0] ^ cyc[2]) : 1'b0;
    for (int k = 0; k < N; k++)
      req_ready[k] <= (qmode == 0) ? 1'b1 : (((cyc + k) % 3) != 0);
  end

  logic [N-1:0] pend;
  logic [31:0]  paddr [N];
  int           lat [N], beat [N], lastb [N];

  always @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      rsp_valid[k] <= 1'b0;
      if (!rst_n) begin
        pend[k] <= 1'b0;
        lastb[k] = -1;
      end else begin
        if (pend[k]) begin
          if (lat[k] > 0) lat[k] <= lat[k] - 1;
          else if (!(gap_mode != 0 && cyc[0])) begin
            rsp_valid[k] <= 1'b1;
            rsp_data[k*SEG_W +: SEG_W] <= segw(paddr[k] + 32'(16 * beat[k]));
            beat[k] <= beat[k] + 1;
            if (beat[k] == SEGS - 1) pend[k] <= 1'b0;
          end
        end
        if (req_valid[k] && req_ready[k]) begin
          int b;
          logic [31:0] a;
          a = req_addr[k*ADDR_W +: ADDR_W];
          b = int'(a >> 7);
          if (pend[k]) r3_err++;
          if (a[6:0] != 7'd0 || (b % N) != k || !(b == k || b == lastb[k] + N)) r2_err++;
          lastb[k] = b;
          pend[k]  <= 1'b1;
          paddr[k] <= a;
          lat[k]   <= 3 + k;
          beat[k]  <= 0;
          total_req = total_req + 1;
        end
      end
    end
  end

  logic         prev_stall = 1'b0;
  logic [511:0] prev_data;
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!rule_valid || rule_data != prev_data)) r6_err++;
      if (rule_valid && rule_ready) begin
        int r;
        r = int'(rule_data[31:0] >> 6);
        for (int j = 0; j < 4; j++)
          if (rule_data[j*128 +: 128] != segw(32'(r * 64 + 16 * j))) r4_err++;
        if (r < 64) begin
          if (seen[r]) dup++;
          seen[r] = 1'b1;
        end else dup++;
        if (em_cnt < 8) logu[em_cnt] = (r >> 1) % N;
        em_cnt = em_cnt + 1;
      end
    end
    prev_stall = rst_n && rule_valid && !rule_ready;
    prev_data  = rule_data;
  end

  task automatic do_reset();
    rst_n = 1'b0; pass_start = 1'b0; rule_count = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      chk(req_valid == '0, "R1", "no request after reset", int'(req_valid), 0);
      chk(rule_valid == 1'b0, "R1", "no rule after reset", int'(rule_valid), 0);
    end
  endtask

  task automatic do_pass(input int c, input int exp_req, input int rm, input int hold,
                         input bit glitch, input string tag);
    int req0, t, e0, miss;
    bit gl_done;
    gl_done = 1'b0;
    seen = '0; dup = 0; em_cnt = 0;
    req0 = total_req;
    rmode = (hold > 0) ? 2 : rm;
    @(negedge clk);
    rule_count = CNT_W'(c); pass_start = 1'b1;
    @(negedge clk);
    pass_start = 1'b0;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(em_cnt == 0, "R6", {tag, " nothing taken while ready low"}, em_cnt, 0);
      rmode = rm;
    end
    t = 0;
    while (em_cnt < c && t < 4000) begin
      @(negedge clk);
      t++;
      if (glitch && !gl_done && em_cnt == 5) begin
        rule_count = CNT_W'(40); pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        gl_done = 1'b1;
      end
    end
    e0 = em_cnt;
    repeat (60) @(negedge clk);
    chk(em_cnt == e0, "R8", {tag, " no emission before next pass"}, em_cnt, e0);
    chk(em_cnt == c, "R5", {tag, " rules emitted"}, em_cnt, c);
    miss = 0;
    for (int i = 0; i < c; i++) if (!seen[i]) miss++;
    chk(miss == 0 && dup == 0, "R5", {tag, " each index once"}, miss + dup, 0);
    chk(total_req - req0 == exp_req, "R8", {tag, " requests incl. run-ahead"}, total_req - req0, exp_req);
  endtask

  initial begin
    #(10 * 150000);
    errors++; checks++;
    $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rmode = 0; qmode = 0; gap_mode = 0;
    do_reset();
    do_pass(40, 25, 0, 0, 1'b0, "A");
    do_pass(40, 20, 0, 0, 1'b0, "B");
    do_pass(6, 0, 0, 0, 1'b0, "C_R10_drop");
    do_pass(13, 8, 0, 0, 1'b0, "D_odd");
    qmode = 1; gap_mode = 1;
    do_pass(13, 7, 1, 0, 1'b0, "E_stall");
    qmode = 0; gap_mode = 0;
    do_pass(32, 19, 0, 80, 1'b0, "F_rr");
    for (int i = 1; i < 8; i++)
      chk(logu[i] == (logu[i-1] + 1) % N, "R7", "round-robin order", logu[i], (logu[i-1] + 1) % N);
    do_pass(24, 11, 1, 0, 1'b1, "G_R9_ignore");
    chk(r2_err == 0, "R2", "request address order", r2_err, 0);
    chk(r3_err == 0, "R3", "single outstanding read", r3_err, 0);
    chk(r4_err == 0, "R4", "rule reassembly", r4_err, 0);
    chk(r6_err == 0, "R6", "hold under backpressure", r6_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule